// File: doc/BRIEF.md
# Collision-Detecting Serial Bus Transmitter

This block shifts a parallel word onto a shared, wired-AND serial line and reads the line back through a separate echo input. Each bit it drives is compared with the echo. The first mismatch shows that another station holds the line low. The block then stops at once, returns its output to the idle high level and raises a sticky collision flag. Several stations can therefore contend for one line without corrupting each other's frames.

The bit timing comes from two single-cycle enable pulses on the system clock. One stands for the rising edge of the transmit clock and one for the falling edge. A mode code, captured with each word, selects which pulse launches a bit and when the echo is checked. Code 001 gives a half-period window: launch on the rising pulse, check on the falling pulse. Code 011 gives a full-period window: launch on a falling pulse, check on the next falling pulse. Any other code turns checking off. A request-to-send output trails the data by one bit period and is high only for bits that left without collision. A second station can use it to re-send those bits one period later on its own line.

Top module: `cd_bus_tx`

## Requirements
- R1: After reset, and whenever no word is in progress, `txd` is 1, `rts` is 0, `done` is 0 and `in_ready` is 1. After reset `col_flag` is 0.
- R2: A word is accepted on a clock edge with `in_valid` and `in_ready` both high. `in_ready` stays low until the word completes or is abandoned. The `mode` code is captured at acceptance, and later changes to `mode` have no effect on that word.
- R3: Bits go out LSB first, one per launch pulse. The first launch pulse after acceptance puts `in_data[0]` on `txd` in the next cycle. The launch pulse after the eighth bit returns `txd` to 1 and raises `done` for exactly one cycle.
- R4: With mode code 001, bits are launched on `bit_en` pulses and the echo is compared on `half_en` pulses.
- R5: With mode code 011, bits are launched and the echo is compared on `half_en` pulses. At each such pulse, the comparison of the bit on the line is made before the next bit is launched.
- R6: With any mode code other than 001 or 011, bits are launched on `bit_en` pulses, `col_in` is never compared, and every word completes with `done`.
- R7: In modes 001 and 011, if `col_in` differs from `txd` at a compare pulse, the word is abandoned. `txd` is 1 and `in_ready` is 1 in the next cycle, no further bits are sent, and `done` is not raised for that word.
- R8: `col_flag` is set in the cycle after a mismatch. It stays set while idle, whatever `col_in` does, and is cleared only when the next word is accepted.
- R9: `rts` changes only in the cycle after a launch pulse. It becomes 1 only if a bit was on the line during the period that pulse ends and that bit was not found colliding. So `rts` lags `txd` by one launch period and drops starting with the colliding bit.
- R10: When `rts_en` is 0 at a launch pulse, `rts` is 0 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse marking a rising transmit-clock edge |
| half_en | input | 1 | One-cycle pulse marking a falling transmit-clock edge |
| mode | input | 3 | Timing-mode code (001 half-period, 011 full-period, others unchecked) |
| rts_en | input | 1 | Allows request-to-send to assert |
| in_valid | input | 1 | Word offered for transmission |
| in_data | input | WORD_W | Word to send, LSB first |
| in_ready | output | 1 | Transmitter idle and able to accept a word |
| col_in | input | 1 | Echo of the shared bus line |
| txd | output | 1 | Serial data driven onto the bus, idle 1 |
| rts | output | 1 | Request-to-send, one bit period behind `txd` |
| done | output | 1 | One-cycle pulse when a word finished without collision |
| col_flag | output | 1 | Sticky collision status |

## Verification
A wrong bit counter or shifter shows on `txd` at the very next launch pulse, either as a misplaced bit or as an early or missing `done`. The bench compares every launched bit against the word it offered. A faulty echo comparison shows within one compare pulse, as an abort where the bus agreed with the data or as a word that runs on past a forced low. A wrong choice of launch or compare pulse for a mode shows in the same way, one pulse later. A wrong request-to-send delay or gating shows on `rts` in the cycle after each launch pulse. The sticky flag is checked after the idle bus has been driven low, so a flag that clears or sets spuriously shows within one idle stretch.

// File: rtl/cdtx_pkg.sv
package cdtx_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] CODE_HALF = 3'b001;
  localparam logic [MODE_W-1:0] CODE_FULL = 3'b011;

  // Checking scheme chosen by the captured mode code
  typedef enum logic [1:0] {
    TM_OPEN = 2'd0,  // no echo check, launch on rising pulse
    TM_HALF = 2'd1,  // launch rising, compare falling
    TM_FULL = 2'd2   // launch falling, compare next falling
  } tmode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } txst_e;

  function automatic tmode_e decode_mode(input logic [MODE_W-1:0] code);
    tmode_e r;
    if (code == CODE_HALF)      r = TM_HALF;
    else if (code == CODE_FULL) r = TM_FULL;
    else                        r = TM_OPEN;
    return r;
  endfunction
endpackage

// File: rtl/cdtx_edge_sel.sv
module cdtx_edge_sel
  import cdtx_pkg::*;
(
  input  tmode_e tm,
  input  logic   bit_en,
  input  logic   half_en,
  output logic   launch_en,
  output logic   sample_en,
  output logic   check_on
);
  // Full-period scheme launches on the falling pulse, others on the rising one
  always_comb begin
    check_on  = (tm != TM_OPEN);
    launch_en = (tm == TM_FULL) ? half_en : bit_en;
    sample_en = half_en & check_on;
  end
endmodule

// File: rtl/cdtx_shifter.sv
module cdtx_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  input  logic              shift,
  output logic              bit_out,
  output logic              all_sent
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= data;
      cnt_q <= '0;
    end else if (shift) begin
      sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_out  = sh_q[0];
  assign all_sent = (cnt_q == CNT_W'(WORD_W));

  // R3: never more bits than a word holds
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WORD_W));
  assert_no_shift_past_end_R3: assert property (@(posedge clk) disable iff (rst)
    (all_sent && !load) |-> !shift);
endmodule

// File: rtl/cdtx_echo.sv
module cdtx_echo (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic active,
  input  logic txd,
  input  logic col_in,
  input  logic clear,
  output logic collide,
  output logic col_flag
);
  assign collide = sample_en & active & (col_in != txd);

  always_ff @(posedge clk) begin
    if (rst)          col_flag <= 1'b0;
    else if (clear)   col_flag <= 1'b0;
    else if (collide) col_flag <= 1'b1;
  end

  // R8: flag holds until a new word clears it
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (col_flag && !clear) |=> col_flag);
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    (collide && !clear) |=> col_flag);
endmodule

// File: rtl/cdtx_rts.sv
module cdtx_rts (
  input  logic clk,
  input  logic rst,
  input  logic launch_en,
  input  logic rts_en,
  input  logic clean,
  output logic rts
);
  // At each launch pulse, mark the bit period just ended if it went out clean
  always_ff @(posedge clk) begin
    if (rst)            rts <= 1'b0;
    else if (launch_en) rts <= rts_en & clean;
  end

  assert_rts_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !launch_en |=> $stable(rts));
  assert_rts_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (launch_en && !rts_en) |=> !rts);
endmodule

// File: rtl/cd_bus_tx.sv
module cd_bus_tx
  import cdtx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              half_en,
  input  logic [2:0]        mode,
  input  logic              rts_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              col_in,
  output logic              txd,
  output logic              rts,
  output logic              done,
  output logic              col_flag
);
  txst_e  state_q;
  tmode_e tm_q;
  logic   txd_q, done_q;
  logic   launch_en, sample_en, check_on;
  logic   bit_out, all_sent, collide;
  logic   load, active, shift, clean;

  assign load   = (state_q == ST_IDLE) & in_valid;
  assign active = (state_q == ST_ACTIVE);

  cdtx_edge_sel u_edge (
    .tm(tm_q), .bit_en(bit_en), .half_en(half_en),
    .launch_en(launch_en), .sample_en(sample_en), .check_on(check_on)
  );

  cdtx_echo u_echo (
    .clk(clk), .rst(rst), .sample_en(sample_en), .active(active),
    .txd(txd_q), .col_in(col_in), .clear(load),
    .collide(collide), .col_flag(col_flag)
  );

  // Compare precedes relaunch when both fall on the same pulse
  assign shift = launch_en & ((state_q == ST_ARMED) |
                              (active & ~collide & ~all_sent));
  assign clean = active & ~collide;

  cdtx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .data(in_data), .shift(shift),
    .bit_out(bit_out), .all_sent(all_sent)
  );

  cdtx_rts u_rts (
    .clk(clk), .rst(rst), .launch_en(launch_en), .rts_en(rts_en),
    .clean(clean), .rts(rts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tm_q    <= TM_OPEN;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            tm_q    <= decode_mode(mode);
            state_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (launch_en) begin
            txd_q   <= bit_out;
            state_q <= ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (collide) begin
            txd_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (launch_en) begin
            if (all_sent) begin
              txd_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              txd_q <= bit_out;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign txd      = txd_q;
  assign done     = done_q;
  assign in_ready = (state_q == ST_IDLE);

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> txd_q);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    collide |=> (txd_q && in_ready && !done_q));
  assert_open_no_check_R6: assert property (@(posedge clk) disable iff (rst)
    !check_on |-> !collide);
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> !in_ready);
endmodule

// File: tb/cd_bus_tx_test.sv
module cd_bus_tx_test;
  localparam int W  = 8;
  localparam int P  = 8;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic bit_en = 1'b0, half_en = 1'b0, rts_en = 1'b0, in_valid = 1'b0;
  logic other_drv = 1'b1;
  logic [2:0]   mode = 3'b000;
  logic [W-1:0] in_data = '0;
  wire in_ready, txd, rts, done, col_flag, col_in;

  // Wired-AND bus: another station can only pull the line low
  assign col_in = txd & other_drv;

  cd_bus_tx #(.WORD_W(W)) uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .half_en(half_en), .mode(mode),
    .rts_en(rts_en), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .col_in(col_in), .txd(txd), .rts(rts),
    .done(done), .col_flag(col_flag)
  );

  // {mode, data, jam-from bit index (8 = none), rts_en}
  localparam logic [15:0] VECS [NV] = '{
    {3'b001, 8'hA5, 4'd8, 1'b1},
    {3'b011, 8'h3C, 4'd8, 1'b1},
    {3'b001, 8'hF0, 4'd2, 1'b1},
    {3'b011, 8'h81, 4'd3, 1'b1},
    {3'b011, 8'h01, 4'd0, 1'b1},
    {3'b000, 8'hFF, 4'd0, 1'b1},
    {3'b101, 8'h55, 4'd1, 1'b1},
    {3'b001, 8'h00, 4'd0, 1'b1},
    {3'b001, 8'h6B, 4'd8, 1'b0},
    {3'b011, 8'hFE, 4'd5, 1'b0}
  };

  int checks = 0, failures = 0;
  int phase = 0, lcount = 0, lim = 0, jam_from = 8, ci = 8;
  logic cur_full = 1'b0, in_frame = 1'b0, pend = 1'b0, cur_ren = 1'b0;
  logic [W-1:0] cur_data = '0;
  string tagm = "R6";

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Output check for the cycle after launch pulse j of the current word
  task automatic observe();
    int j;
    logic et, er, ed;
    if (pend) begin
      j = lcount - 1;
      if (j <= ci && j < W) begin
        et = cur_data[j];
        ed = 1'b0;
      end else begin
        et = 1'b1;
        ed = (ci == W && j == W);
      end
      er = cur_ren && (j >= 1) && ((j - 1) < ci) && ((j - 1) < W);
      chk(txd == et, {tagm, " R3 R7 txd"}, int'(txd), int'(et));
      chk(rts == er, cur_ren ? "R9 rts" : "R10 rts", int'(rts), int'(er));
      chk(done == ed, "R3 R7 done", int'(done), int'(ed));
    end
  endtask

  task automatic tick();
    logic launch;
    @(negedge clk);
    observe();
    if (pend && (lcount - 1) == jam_from) other_drv = 1'b0;
    phase   = (phase + 1) % P;
    bit_en  = (phase == 0);
    half_en = (phase == P / 2);
    launch  = cur_full ? half_en : bit_en;
    if (in_frame && launch && lcount < lim) begin
      lcount++;
      pend = 1'b1;
    end else begin
      pend = 1'b0;
    end
  endtask

  task automatic run_vec(input logic [15:0] v);
    logic checking;
    mode     = v[15:13];
    in_data  = v[12:5];
    jam_from = int'(v[4:1]);
    cur_ren  = v[0];
    rts_en   = cur_ren;
    cur_data = in_data;
    cur_full = (mode == 3'b011);
    checking = (mode == 3'b001) || (mode == 3'b011);
    tagm     = (mode == 3'b001) ? "R4" : (mode == 3'b011) ? "R5" : "R6";
    ci = W;
    if (checking)
      for (int i = jam_from; i < W; i++)
        if (cur_data[i] && ci == W) ci = i;
    lim = (ci == W) ? W + 2 : ci + 2;
    lcount   = 0;
    pend     = 1'b0;
    in_valid = 1'b1;
    in_frame = 1'b1;
    tick();
    in_valid = 1'b0;
    mode     = 3'b111;  // later mode changes must not matter (R2)
    chk(in_ready == 1'b0, "R2 busy after accept", int'(in_ready), 0);
    chk(col_flag == 1'b0, "R8 flag cleared on accept", int'(col_flag), 0);
    while (lcount < lim || pend) tick();
    in_frame = 1'b0;
    chk(in_ready == 1'b1, "R2 ready after word", int'(in_ready), 1);
    chk(col_flag == (ci < W), "R7 R8 collision flag", int'(col_flag), int'(ci < W));
    other_drv = 1'b0;  // idle bus held low must not disturb state
    repeat (2 * P) tick();
    chk(col_flag == (ci < W), "R8 flag holds while idle", int'(col_flag), int'(ci < W));
    chk(txd == 1'b1, "R1 idle txd", int'(txd), 1);
    chk(rts == 1'b0, "R1 idle rts", int'(rts), 0);
    other_drv = 1'b1;
    jam_from  = W;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    lim = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(rts == 1'b0, "R1 reset rts", int'(rts), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(col_flag == 1'b0, "R1 reset col_flag", int'(col_flag), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // Reset in the middle of a word
    mode = 3'b001; in_data = 8'h00; rts_en = 1'b1; cur_full = 1'b0;
    in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    repeat (3 * P) tick();
    chk(txd == 1'b0, "R3 zero bit on line", int'(txd), 0);
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    tick();
    chk(txd == 1'b1, "R1 mid-word reset txd", int'(txd), 1);
    chk(rts == 1'b0, "R1 mid-word reset rts", int'(rts), 0);
    chk(in_ready == 1'b1, "R1 mid-word reset ready", int'(in_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule